// File: doc/BRIEF.md
# Dual-Clock Raster Line Delay Memory

This block stores one raster line of pixels and plays it back later, so that an image pipeline can see the current line and an earlier line at the same moment. It has two sides with fully independent clocks. Each side has an active-low enable and an active-low synchronous restart. Each side also has a free-running address counter that steps once for every enabled clock edge and wraps at the end of the line. The counters are never compared with each other. There is no full flag and no empty flag. The user sets the delay by choosing when each side is restarted.

A write byte is sampled at one write-clock edge and enters the array at the next write-clock edge. A read happens at the read-clock edge that starts the read. Because of this one-edge offset on the write side, a design that restarts both sides on the same edge and keeps both enables low gets an output that repeats its input exactly one line length later. The three-state output pins are modelled as a data bus plus a separate valid/drive bit. The bus reads zero whenever that bit is low.

Top module: `line_delay_mem`

## Requirements
- R1: The array holds DEPTH words of WIDTH bits (defaults 1152 and 8). A byte accepted at a write address can later be read back unchanged from that same address.
- R2: At a write-clock edge with `wrEnN` high, the array is left unchanged and the write counter keeps its value. The next accepted byte goes to the address that follows the last accepted one.
- R3: At a write-clock edge with `wrRstN` low, the edge uses address 0. If `wrEnN` is low, the byte is stored at address 0 and the counter then moves to 1. If `wrEnN` is high, the counter stays at 0.
- R4: At a read-clock edge with `rdEnN` low, `rdData` takes the word at the current read address and `rdDataEn` goes high. Both are valid right after that edge, and the read counter then advances by one.
- R5: At a read-clock edge with `rdEnN` high, `rdDataEn` goes low and `rdData` reads 0. The read counter keeps its value, so the next enabled read continues from where reading stopped.
- R6: While `rdRstN` is held low with `rdEnN` low, every read edge outputs word 0. The first enabled edge after release outputs word 1.
- R7: A byte sampled at write edge k is stored in the array at write edge k+1. A read of that address taken at or before edge k+1 returns the previous contents.
- R8: Both counters go from DEPTH-1 back to 0 without any flag or pause.
- R9: Suppose both sides share one clock, both restarts are released on the same edge, and both enables stay low. Then the byte output after edge k equals the byte input at edge k-DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| wrEnN | input | 1 | Write enable, active low |
| wrRstN | input | 1 | Write address restart, active low, synchronous to wrClk |
| wrData | input | WIDTH | Byte to be stored |
| rdClk | input | 1 | Read-side clock |
| rdEnN | input | 1 | Read enable, active low |
| rdRstN | input | 1 | Read address restart, active low, synchronous to rdClk |
| rdData | output | WIDTH | Word read out; zero while not driven |
| rdDataEn | output | 1 | High when rdData is being driven (stands in for the three-state pins) |

## Verification
The read results and `rdDataEn` change at the read-clock edge that samples `rdEnN`. The bench therefore checks them one nanosecond after that edge, and it never samples before the edge. A written byte only becomes readable one write edge after it is sampled. Before reading back, the bench either allows an extra write edge or, in the shared-clock phase, reads on exactly that following edge on purpose and expects the old contents. In the one-line-delay sweep, the bench compares the output after edge k with its own record of the input pattern at edge k minus DEPTH. That pattern is computed arithmetically.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
  parameter int unsigned LDM_DEPTH = 1152;
  parameter int unsigned LDM_WIDTH = 8;
  localparam int unsigned LDM_AW   = $clog2(LDM_DEPTH);

  // Per-side strobe from a control unit to the datapath.
  typedef struct packed {
    logic              take;   // access this edge
    logic [LDM_AW-1:0] addr;   // address used this edge
  } ldm_stb_t;
endpackage

// File: rtl/ldm_side_ctrl.sv
module ldm_side_ctrl
  import ldm_pkg::*;
#(
  parameter int unsigned DEPTH = LDM_DEPTH
) (
  input  logic     clk,
  input  logic     enN,
  input  logic     rstN,
  output ldm_stb_t stb
);
  localparam int unsigned AW   = LDM_AW;
  localparam int unsigned LAST = DEPTH - 1;

  logic [AW-1:0] cnt;
  logic [AW-1:0] nowAddr;
  logic [AW-1:0] nextAddr;
  logic          armed;

  // A restart edge works on address 0 in the same edge.
  always_comb begin
    nowAddr  = rstN ? cnt : '0;
    nextAddr = (nowAddr == AW'(LAST)) ? '0 : nowAddr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!enN) cnt <= nextAddr;
    else      cnt <= nowAddr;
  end

  // Set by the first restart; qualifies the checks below.
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b1;
  end

  assign stb = '{take: !enN, addr: nowAddr};

  a_r8_wrap: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!enN && nowAddr == AW'(LAST)) |=> (cnt == '0));

  a_r3_restart: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!rstN) |=> (cnt == ($past(enN) ? AW'(0) : AW'(1))));

  // R2 on the write side, R5 on the read side
  a_r2_hold: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (enN && rstN) |=> $stable(cnt));

  a_r4_step: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!enN && rstN && cnt != AW'(LAST)) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/ldm_datapath.sv
module ldm_datapath
  import ldm_pkg::*;
#(
  parameter int unsigned DEPTH = LDM_DEPTH,
  parameter int unsigned WIDTH = LDM_WIDTH
) (
  input  logic             wClk,
  input  ldm_stb_t         wStb,
  input  logic [WIDTH-1:0] wData,
  input  logic             rClk,
  input  ldm_stb_t         rStb,
  output logic [WIDTH-1:0] rWord,
  output logic             rDrive
);
  localparam int unsigned AW = LDM_AW;

  logic [WIDTH-1:0] mem [DEPTH];

  // One-edge write pipeline: sample now, commit at the next write edge.
  logic             pendTake;
  logic [AW-1:0]    pendAddr;
  logic [WIDTH-1:0] pendData;

  always_ff @(posedge wClk) begin
    if (pendTake) mem[pendAddr] <= pendData;
    pendTake <= wStb.take;
    pendAddr <= wStb.addr;
    pendData <= wData;
  end

  logic [WIDTH-1:0] outReg;
  logic             outOn;

  always_ff @(posedge rClk) begin
    if (rStb.take) outReg <= mem[rStb.addr];
    outOn <= rStb.take;
  end

  assign rDrive = outOn;
  assign rWord  = outOn ? outReg : '0;

  a_r7_commit: assert property (@(posedge wClk)
    disable iff ($isunknown({pendTake, pendAddr}))
    pendTake |=> (mem[$past(pendAddr)] == $past(pendData)));

  a_r5_quiet: assert property (@(posedge rClk)
    disable iff ($isunknown(rStb))
    (!rStb.take) |=> (!rDrive && rWord == '0));

  a_r4_drive: assert property (@(posedge rClk)
    disable iff ($isunknown(rStb))
    rStb.take |=> rDrive);
endmodule

// File: rtl/line_delay_mem.sv
module line_delay_mem
  import ldm_pkg::*;
#(
  parameter int unsigned DEPTH = LDM_DEPTH,
  parameter int unsigned WIDTH = LDM_WIDTH
) (
  input  logic             wrClk,
  input  logic             wrEnN,
  input  logic             wrRstN,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdClk,
  input  logic             rdEnN,
  input  logic             rdRstN,
  output logic [WIDTH-1:0] rdData,
  output logic             rdDataEn
);
  ldm_stb_t wrStb;
  ldm_stb_t rdStb;

  ldm_side_ctrl #(.DEPTH(DEPTH)) u_wrCtrl (
    .clk(wrClk), .enN(wrEnN), .rstN(wrRstN), .stb(wrStb)
  );

  ldm_side_ctrl #(.DEPTH(DEPTH)) u_rdCtrl (
    .clk(rdClk), .enN(rdEnN), .rstN(rdRstN), .stb(rdStb)
  );

  ldm_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .wClk(wrClk), .wStb(wrStb), .wData(wrData),
    .rClk(rdClk), .rStb(rdStb), .rWord(rdData), .rDrive(rdDataEn)
  );
endmodule

// File: tb/test_line_delay_mem.sv
`timescale 1ns/1ps
module test_line_delay_mem;
  localparam int DEPTH = 1152;

  logic       wrClk = 1'b0, rdClk = 1'b0, sameClk = 1'b0;
  logic       wrEnN = 1'b1, wrRstN = 1'b1, rdEnN = 1'b1, rdRstN = 1'b1;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       rdDataEn;
  int         nChecks = 0, nFails = 0;
  logic       done = 1'b0;

  line_delay_mem i_line_delay_mem (
    .wrClk(wrClk), .wrEnN(wrEnN), .wrRstN(wrRstN), .wrData(wrData),
    .rdClk(rdClk), .rdEnN(rdEnN), .rdRstN(rdRstN),
    .rdData(rdData), .rdDataEn(rdDataEn)
  );

  always #2.5 wrClk = ~wrClk;   // 200 MHz
  always begin
    if (sameClk) begin @(wrClk); rdClk = wrClk; end
    else begin #3.5; rdClk = ~rdClk; end
  end

  function automatic logic [7:0] patA(int i); return 8'((i * 37 + 11) % 256); endfunction
  function automatic logic [7:0] patB(int i); return 8'((i * 53 + 90) % 256); endfunction
  function automatic logic [7:0] patC(int i); return 8'((i * 29 + 5) % 256); endfunction

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got en/data %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wStep(logic en, logic rs, logic [7:0] d);
    @(negedge wrClk); wrEnN = en; wrRstN = rs; wrData = d;
    @(posedge wrClk);
  endtask

  task automatic rStep(logic en, logic rs, output logic [8:0] q);
    @(negedge rdClk); rdEnN = en; rdRstN = rs;
    @(posedge rdClk); #1; q = {rdDataEn, rdData};
  endtask

  task automatic bStep(logic we, logic wr, logic [7:0] d, logic re, logic rr,
                       output logic [8:0] q);
    @(negedge wrClk); wrEnN = we; wrRstN = wr; wrData = d; rdEnN = re; rdRstN = rr;
    @(posedge wrClk); #1; q = {rdDataEn, rdData};
  endtask

  initial begin
    logic [8:0] q;
    // Reset state: restarts held, enables high
    for (int i = 0; i < 3; i++) wStep(1, 0, 8'h00);
    for (int i = 0; i < 3; i++) begin
      rStep(1, 0, q); chk("R5 reset state", q, 9'h000);
    end
    // R1/R3: fill a whole line from a restart edge
    for (int i = 0; i < DEPTH; i++) wStep(0, (i == 0) ? 1'b0 : 1'b1, patA(i));
    wStep(1, 1, 8'h00); wStep(1, 1, 8'h00);
    // R6: held read restart repeats word 0
    for (int i = 0; i < 3; i++) begin
      rStep(0, 0, q); chk("R6 held restart", q, {1'b1, patA(0)});
    end
    for (int i = 1; i < DEPTH; i++) begin
      rStep(0, 1, q); chk("R1 R4 line readback", q, {1'b1, patA(i)});
    end
    rStep(0, 1, q); chk("R8 read wrap", q, {1'b1, patA(0)});
    for (int i = 0; i < 2; i++) begin
      rStep(1, 1, q); chk("R5 disabled read", q, 9'h000);
    end
    rStep(0, 1, q); chk("R5 counter held", q, {1'b1, patA(1)});
    // R2: disabled write edges are ignored
    wStep(0, 0, 8'hA5);
    for (int i = 0; i < 3; i++) wStep(1, 1, 8'h3C);
    wStep(0, 1, 8'h5A);
    wStep(1, 1, 8'h00); wStep(1, 1, 8'h00);
    rStep(0, 0, q); chk("R3 write restart addr0", q, 9'h1A5);
    rStep(0, 1, q); chk("R2 write counter held", q, 9'h15A);
    rStep(0, 1, q); chk("R2 ignored byte not stored", q, {1'b1, patA(2)});
    // R3: restart with enable high leaves counter at 0
    wStep(1, 0, 8'hFF); wStep(0, 1, 8'h77);
    wStep(1, 1, 8'h00); wStep(1, 1, 8'h00);
    rStep(0, 0, q); chk("R3 restart with enable high", q, 9'h177);
    rStep(0, 1, q); chk("R3 next address untouched", q, 9'h15A);
    // R8: write counter wraps onto address 0
    for (int i = 0; i < DEPTH; i++) wStep(0, (i == 0) ? 1'b0 : 1'b1, patB(i));
    wStep(0, 1, 8'hEE);
    wStep(1, 1, 8'h00); wStep(1, 1, 8'h00);
    rStep(0, 0, q); chk("R8 write wrap", q, 9'h1EE);
    rStep(0, 1, q); chk("R8 after wrap", q, {1'b1, patB(1)});
    rStep(0, 1, q); chk("R1 second line", q, {1'b1, patB(2)});

    // Shared clock phase
    rStep(1, 1, q);
    sameClk = 1'b1;
    for (int i = 0; i < 4; i++) bStep(1, 1, 8'h00, 1, 1, q);
    // R7: read on the commit edge sees old contents
    bStep(0, 0, 8'h11, 1, 1, q);
    bStep(0, 1, 8'h22, 0, 0, q); chk("R7 read before commit", q, 9'h1EE);
    bStep(1, 1, 8'h00, 0, 0, q); chk("R7 read after commit", q, 9'h111);
    // R9: one-line delay with both restarts released together
    bStep(0, 0, patC(0), 0, 0, q);
    for (int k = 1; k <= 2 * DEPTH + 5; k++) begin
      bStep(0, 1, patC(k), 0, 1, q);
      if (k >= DEPTH) chk("R9 one-line delay", q, {1'b1, patC(k - DEPTH)});
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule